// File: doc/BRIEF.md
# Vertical Max-Pooling Stage with Per-Column Row History

This block is the second half of a separable two-dimensional max pool. An upstream stage has already reduced each row along its width, and it delivers those row-maximum samples here in raster order. Each sample carries its column index. Each one is also marked when it opens a new channel and when it belongs to the channel's final row. For every column position, the block produces the maximum over a vertical window of `k` rows. `k` can be chosen per channel, from 2 up to a build-time ceiling `K`. Rows above the image and below it count as zero.

The block keeps one comparator cascade, and every column shares it, because samples from different columns arrive in separate cycles. Each column's earlier rows are held in a lag-by-column memory. When a sample passes, the memory reads out that column's history and writes it back shifted by one row, with the new sample in the youngest slot. When the last row of a channel has been accepted, the block generates the zero rows for the bottom margin by itself. While it does so, it refuses input.

For window size `k`, write A = floor(k/2) and B = floor((k-1)/2). The output for row `i` covers rows `i-A` to `i+B`.

Top module: `colmax_pool`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: The output for row i, column j is the largest input value of column j over rows i-A to i+B, where A = floor(k/2) and B = floor((k-1)/2). Rows outside 0..H-1 contribute the value 0, and data is unsigned.
- R3: `k` is taken from `ksel` on the accepted sample that has `in_chan_start` set, and it holds for the whole channel. A `ksel` below 2 acts as 2, and a `ksel` above `K` acts as `K`.
- R4: Each channel of H rows of W samples yields exactly H·W outputs. They come in raster order: row by row, with `out_col` stepping 0..W-1 within each row.
- R5: A sample is the last of a channel when it is accepted in column W-1 with `in_last_row` high. After such a sample, `in_ready` stays low for exactly B·W cycles and then returns high. When k = 2, `in_ready` does not drop.
- R6: The first rows of a new channel take no value from any earlier channel. History rows that lie before the channel start count as zero.
- R7: A sample that is presented while `in_ready` is low has no effect, whatever its data, column or strobe values.
- R8: The output for row i, column j appears two clock cycles after the block accepts the input sample for row i+B, column j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ksel | input | KW | Requested window height, read on the channel-start sample |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts input; low while bottom padding is generated |
| in_chan_start | input | 1 | Marks the first sample (row 0, column 0) of a channel |
| in_last_row | input | 1 | Marks samples of the final row of a channel |
| in_col | input | CW | Column index 0..W-1 of the sample |
| in_data | input | DW | Row-maximum sample value (unsigned) |
| out_valid | output | 1 | Output sample present |
| out_col | output | CW | Column index of the output sample |
| out_data | output | DW | Vertical window maximum |

## Verification
The hardest case to reach is a channel shorter than the bottom margin. With k = 13 and only three rows, every output is produced during the internally generated padding rows. Those outputs also depend on history slots that are masked because they lie before the channel start. The bench drives exactly that short channel. Directly before it comes a channel of large values, so any history leaking across the channel boundary would show up in the results. A separate channel keeps `in_valid` high, with hostile data and strobes, through the whole padding interval. This shows that input offered while `in_ready` is low changes neither the outputs nor the padding length.

// File: rtl/colmax_pkg.sv
package colmax_pkg;
  // Effective window height: requests outside 2..kmax are pulled to the edge.
  function automatic int clamp_k(input int req, input int kmax);
    if (req < 2) return 2;
    if (req > kmax) return kmax;
    return req;
  endfunction

  // Rows of the window below the output row.
  function automatic int rows_below(input int k);
    return (k - 1) / 2;
  endfunction
endpackage

// File: rtl/colmax_ctrl.sv
module colmax_ctrl
  import colmax_pkg::*;
#(
  parameter int K  = 13,
  parameter int W  = 32,
  parameter int DW = 8,
  parameter int KW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] ksel,
  input  logic          in_valid,
  input  logic          in_chan_start,
  input  logic          in_last_row,
  input  logic [CW-1:0] in_col,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          rd_en,
  output logic [CW-1:0] rd_col,
  output logic          s1_valid,
  output logic [CW-1:0] s1_col,
  output logic [DW-1:0] s1_data,
  output logic [KW-1:0] s1_row,
  output logic [KW-1:0] s1_k
);
  logic          pad_active;
  logic [CW-1:0] pad_col;
  logic [KW-1:0] pad_left;
  logic [KW-1:0] row_cnt;
  logic [KW-1:0] k_reg;

  logic          accept, s0_valid, row_end, open_ch;
  logic [CW-1:0] s0_col;
  logic [DW-1:0] s0_data;
  logic [KW-1:0] k_now, row_now, b_now;

  always_comb begin
    accept   = in_valid && !pad_active;
    open_ch  = accept && in_chan_start;
    s0_valid = accept || pad_active;
    s0_col   = pad_active ? pad_col : in_col;
    s0_data  = pad_active ? '0 : in_data;
    k_now    = open_ch ? KW'(clamp_k(int'(ksel), K)) : k_reg;
    row_now  = open_ch ? '0 : row_cnt;
    b_now    = KW'(rows_below(int'(k_now)));
    row_end  = s0_valid && (s0_col == CW'(W - 1));
  end

  assign in_ready = !pad_active;
  assign rd_en    = s0_valid;
  assign rd_col   = s0_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_active <= 1'b0;
      pad_col    <= '0;
      pad_left   <= '0;
      row_cnt    <= '0;
      k_reg      <= KW'(2);
      s1_valid   <= 1'b0;
      s1_col     <= '0;
      s1_data    <= '0;
      s1_row     <= '0;
      s1_k       <= KW'(2);
    end else begin
      s1_valid <= s0_valid;
      if (s0_valid) begin
        s1_col  <= s0_col;
        s1_data <= s0_data;
        s1_row  <= row_now;
        s1_k    <= k_now;
        if (row_end)
          row_cnt <= (row_now == KW'(K)) ? row_now : row_now + 1'b1;
        else
          row_cnt <= row_now;
      end
      if (open_ch) k_reg <= k_now;
      if (accept && in_last_row && row_end && b_now != '0) begin
        pad_active <= 1'b1;
        pad_col    <= '0;
        pad_left   <= b_now - 1'b1;
      end else if (pad_active) begin
        if (row_end) begin
          pad_col <= '0;
          if (pad_left == '0) pad_active <= 1'b0;
          else                pad_left   <= pad_left - 1'b1;
        end else begin
          pad_col <= pad_col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/colmax_hist.sv
module colmax_hist #(
  parameter int K  = 13,
  parameter int W  = 32,
  parameter int DW = 8,
  parameter int KW = 4,
  parameter int CW = 5
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [CW-1:0]           rd_col,
  input  logic                    wr_en,
  input  logic [CW-1:0]           wr_col,
  input  logic [DW-1:0]           wr_data,
  input  logic [KW-1:0]           row,
  output logic [K-2:0][DW-1:0]    hist_m
);
  localparam int LAGS = K - 1;

  for (genvar l = 0; l < LAGS; l++) begin : g_lag
    logic [DW-1:0] mem [W];
    logic [DW-1:0] rd_q;
    logic [DW-1:0] wr_val;

    if (l == 0) begin : g_young
      assign wr_val = wr_data;
    end else begin : g_older
      assign wr_val = hist_m[l-1];
    end

    // Lag l holds row (current - 1 - l); it exists only once that many rows passed.
    assign hist_m[l] = (KW'(l) < row) ? rd_q : '0;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_col] <= wr_val;
      if (rd_en) rd_q <= mem[rd_col];
    end
  end
endmodule

// File: rtl/colmax_cascade.sv
module colmax_cascade
  import colmax_pkg::*;
#(
  parameter int K  = 13,
  parameter int DW = 8,
  parameter int KW = 4,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s1_valid,
  input  logic [CW-1:0]        s1_col,
  input  logic [DW-1:0]        s1_data,
  input  logic [KW-1:0]        s1_row,
  input  logic [KW-1:0]        s1_k,
  input  logic [K-2:0][DW-1:0] hist_m,
  output logic                 out_valid,
  output logic [CW-1:0]        out_col,
  output logic [DW-1:0]        out_data
);
  logic [K-1:0][DW-1:0] part;
  logic [DW-1:0]        pick;
  logic                 emit;

  assign part[0] = s1_data;
  for (genvar w = 1; w < K; w++) begin : g_stage
    assign part[w] = (part[w-1] > hist_m[w-1]) ? part[w-1] : hist_m[w-1];
  end

  always_comb begin
    pick = part[0];
    for (int w = 0; w < K; w++)
      if (KW'(w + 1) == s1_k) pick = part[w];
    emit = s1_valid && (s1_row >= KW'(rows_below(int'(s1_k))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_col   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_col  <= s1_col;
        out_data <= pick;
      end
    end
  end
endmodule

// File: rtl/colmax_pool.sv
module colmax_pool #(
  parameter int K  = 13,
  parameter int W  = 32,
  parameter int DW = 8,
  localparam int KW = $clog2(K + 1),
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] ksel,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_chan_start,
  input  logic          in_last_row,
  input  logic [CW-1:0] in_col,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [CW-1:0] out_col,
  output logic [DW-1:0] out_data
);
  logic                 rd_en, s1_valid;
  logic [CW-1:0]        rd_col, s1_col;
  logic [DW-1:0]        s1_data;
  logic [KW-1:0]        s1_row, s1_k;
  logic [K-2:0][DW-1:0] hist_m;

  colmax_ctrl #(.K(K), .W(W), .DW(DW), .KW(KW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .ksel(ksel), .in_valid(in_valid),
    .in_chan_start(in_chan_start), .in_last_row(in_last_row),
    .in_col(in_col), .in_data(in_data), .in_ready(in_ready),
    .rd_en(rd_en), .rd_col(rd_col), .s1_valid(s1_valid), .s1_col(s1_col),
    .s1_data(s1_data), .s1_row(s1_row), .s1_k(s1_k)
  );

  colmax_hist #(.K(K), .W(W), .DW(DW), .KW(KW), .CW(CW)) u_hist (
    .clk(clk), .rd_en(rd_en), .rd_col(rd_col), .wr_en(s1_valid),
    .wr_col(s1_col), .wr_data(s1_data), .row(s1_row), .hist_m(hist_m)
  );

  colmax_cascade #(.K(K), .DW(DW), .KW(KW), .CW(CW)) u_casc (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_col(s1_col),
    .s1_data(s1_data), .s1_row(s1_row), .s1_k(s1_k), .hist_m(hist_m),
    .out_valid(out_valid), .out_col(out_col), .out_data(out_data)
  );
endmodule

// File: rtl/colmax_pool_chk.sv
module colmax_pool_chk #(
  parameter int W  = 32,
  parameter int DW = 8,
  parameter int KW = 4,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last_row,
  input logic [CW-1:0] in_col,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [CW-1:0] out_col,
  input logic [DW-1:0] out_data
);
  logic [1:0]    age;
  logic [CW-1:0] exp_col;
  logic          acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      exp_col <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (out_valid) exp_col <= (out_col == CW'(W - 1)) ? '0 : out_col + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  assert_newest_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid && $past(acc, 2))
      |-> (out_data >= $past(in_data, 2) && out_col == $past(in_col, 2)));

  assert_raster_order_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_col == exp_col));

  assert_pad_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $fell(in_ready))
      |-> $past(acc && in_last_row && in_col == CW'(W - 1)));
endmodule

bind colmax_pool colmax_pool_chk #(.W(W), .DW(DW), .KW(KW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last_row(in_last_row), .in_col(in_col), .in_data(in_data),
  .out_valid(out_valid), .out_col(out_col), .out_data(out_data)
);

// File: tb/colmax_pool_tb.sv
`timescale 1ns/1ps
module colmax_pool_tb;
  localparam int K  = 13;
  localparam int W  = 32;
  localparam int DW = 8;
  localparam int KW = $clog2(K + 1);
  localparam int CW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [KW-1:0] ksel = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_chan_start = 1'b0;
  logic          in_last_row = 1'b0;
  logic [CW-1:0] in_col = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [CW-1:0] out_col;
  logic [DW-1:0] out_data;

  int total = 0;
  int bad   = 0;
  int   q_col[$];
  int   q_dat[$];
  string q_req[$];
  int img [0:31][0:31];

  always #2 clk = ~clk;

  colmax_pool #(.K(K), .W(W), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ksel(ksel), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan_start(in_chan_start), .in_last_row(in_last_row), .in_col(in_col),
    .in_data(in_data), .out_valid(out_valid), .out_col(out_col), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_dat.size() == 0) begin
        check(1'b0, "R4 unexpected output", int'(out_data), -1);
      end else begin
        int ec, ed;
        string er;
        ec = q_col.pop_front();
        ed = q_dat.pop_front();
        er = q_req.pop_front();
        check(int'(out_col) == ec, {er, " column"}, int'(out_col), ec);
        check(int'(out_data) == ed, {er, " data"}, int'(out_data), ed);
      end
    end
  end

  // mode: 0 mixed pattern, 1 large values, 2 small values
  task automatic run_ch(input int kreq, input int h, input int seed, input int mode,
                        input bit gaps, input bit poke, input bit lat, input string req);
    int keff, a, b, cnt;
    keff = (kreq < 2) ? 2 : (kreq > K ? K : kreq);
    a = keff / 2;
    b = (keff - 1) / 2;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < W; c++) begin
        int v;
        v = (seed * 37 + r * 53 + c * 29 + r * c * 7) & 255;
        if (mode == 1) v = 200 + (v % 50);
        if (mode == 2) v = v % 20;
        img[r][c] = v;
      end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < W; c++) begin
        int m;
        m = 0;
        for (int l = r - a; l <= r + b; l++)
          if (l >= 0 && l < h && img[l][c] > m) m = img[l][c];
        q_col.push_back(c);
        q_dat.push_back(m);
        q_req.push_back(req);
      end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < W; c++) begin
        @(negedge clk);
        in_valid = 1'b0;
        if (gaps && ((r + c) % 3 == 0)) @(negedge clk);
        ksel          = KW'(kreq);
        in_chan_start = (r == 0 && c == 0);
        in_last_row   = (r == h - 1);
        in_col        = CW'(c);
        in_data       = DW'(img[r][c]);
        in_valid      = 1'b1;
        if (lat && r == 0 && c == 0) begin
          @(negedge clk);
          in_valid = 1'b0;
          @(negedge clk);
          // R8: k=2 means B=0, so row 0 col 0 emerges two cycles after acceptance
          check(out_valid == 1'b1 && out_col == '0, "R8 latency", int'(out_valid), 1);
        end
      end
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    while (!in_ready) begin
      if (poke) begin
        in_valid = 1'b1; in_chan_start = 1'b1; in_last_row = 1'b1;
        in_col = CW'(W - 1); in_data = '1; ksel = KW'(2);
      end
      cnt++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_chan_start = 1'b0;
    in_last_row = 1'b0;
    if (poke) check(cnt == b * W, "R7 padding length with ignored input", cnt, b * W);
    else      check(cnt == b * W, "R5 padding length", cnt, b * W);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset",
          int'({out_valid, in_ready}), 1);
    run_ch(5, 6, 1, 0, 1'b0, 1'b0, 1'b0, "R2 k5");
    run_ch(3, 4, 2, 0, 1'b1, 1'b0, 1'b0, "R2 k3 gaps");
    run_ch(4, 5, 3, 0, 1'b0, 1'b0, 1'b0, "R2 k4 even");
    run_ch(9, 10, 4, 1, 1'b0, 1'b0, 1'b0, "R6 big");
    run_ch(13, 3, 5, 2, 1'b1, 1'b0, 1'b0, "R6 short after big");
    run_ch(1, 3, 6, 0, 1'b0, 1'b0, 1'b0, "R3 clamp low");
    run_ch(15, 16, 7, 0, 1'b0, 1'b0, 1'b0, "R3 clamp high");
    run_ch(2, 2, 8, 0, 1'b0, 1'b0, 1'b1, "R8 k2");
    run_ch(7, 4, 9, 0, 1'b0, 1'b1, 1'b0, "R7 poke");
    run_ch(11, 12, 10, 0, 1'b1, 1'b0, 1'b0, "R2 k11");
    repeat (10) @(negedge clk);
    check(q_dat.size() == 0, "R4 outstanding outputs", q_dat.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 60000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule